// File: doc/BRIEF.md
# Two-Way Register Mailbox

This block lets software and a hardware agent exchange 32-bit words through two independent FIFOs that sit behind one small register window. Software stores to the data register fill the outbound FIFO, and the hardware side drains it through a valid/pop handshake. The hardware side fills the inbound FIFO through a ready/push handshake, and software drains it by loading the same data register. Each load of the data register removes one entry.

Software watches the two FIFOs through a status word and through two level interrupts. Each interrupt has its own 3-bit threshold and stays high while its FIFO holds more entries than the threshold. Two sticky error flags record a store into a full outbound FIFO and a load from an empty inbound FIFO, and these flags drive a third interrupt. A control register can empty either FIFO in one cycle.

The register port is a plain single-cycle request with a write flag, a 3-bit word address, write data and combinational read data.

Top module: `mbox_bridge`

## Requirements
- R1: A bus write to address 0 stores the full 32-bit write data into the outbound FIFO. The hardware side sees the entries in store order on `hw_wr_data`, with `hw_wr_valid` high while the FIFO holds data, and each `hw_wr_pop` removes one entry.
- R2: A bus read of address 0 returns the oldest inbound entry and removes it. Entries come out in the order that `hw_rd_push` delivered them.
- R3: A read of address 1 returns the status word. Bit 0 is 1 when the inbound FIFO is empty. Bit 1 is 1 when the outbound FIFO is full. Bit 2 is 1 when the outbound level exceeds the outbound threshold. Bit 3 is 1 when the inbound level exceeds the inbound threshold. Bits 31:4 read 0.
- R4: A bus write to address 0 while the outbound FIFO is full is discarded, leaves the FIFO contents unchanged, and sets bit 1 of the error register.
- R5: A bus read of address 0 while the inbound FIFO is empty returns 0, sets bit 0 of the error register, and leaves the FIFO unchanged.
- R6: The error register at address 2 is sticky. Writing 1 to a bit clears that bit, and writing 0 leaves it unchanged. If an error and its clear occur in the same cycle, the flag is set.
- R7: The outbound threshold at address 3 and the inbound threshold at address 4 are 3-bit read/write fields in bits 2:0. Both reset to 0, and their upper bits read 0.
- R8: `irq_wr_thr` is high exactly while the outbound level exceeds the outbound threshold. `irq_rd_thr` is high exactly while the inbound level exceeds the inbound threshold.
- R9: `irq_err` is the OR of the two error bits, so it rises only in the cycle after an erroneous access.
- R10: A write to the control register at address 5 with bit 0 set empties the inbound FIFO, and with bit 1 set empties the outbound FIFO, both in one cycle. The control register always reads 0.
- R11: `hw_rd_ready` is low while the inbound FIFO is full, and a push at that time is ignored. A `hw_wr_pop` while the outbound FIFO is empty is ignored.
- R12: After reset both FIFOs are empty, the status word reads 1, the error and threshold registers read 0, and all interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| hw_wr_valid | output | 1 | Outbound FIFO holds data |
| hw_wr_data | output | 32 | Oldest outbound entry |
| hw_wr_pop | input | 1 | Remove the oldest outbound entry |
| hw_rd_ready | output | 1 | Inbound FIFO can accept an entry |
| hw_rd_push | input | 1 | Push `hw_rd_data` into the inbound FIFO |
| hw_rd_data | input | 32 | Inbound data |
| irq_wr_thr | output | 1 | Outbound level above its threshold |
| irq_rd_thr | output | 1 | Inbound level above its threshold |
| irq_err | output | 1 | An error flag is set |

## Verification
The assertions check several properties on every cycle. Each FIFO level stays within the FIFO depth. An accepted push without a pop raises the level by one. A flush leaves the FIFO empty. A store that a full FIFO refuses does not change the level. A threshold interrupt is never high while its FIFO is empty. The error interrupt rises only after an erroneous access.

Only the bench scenarios can show that data keeps its value and order through both FIFOs. The same applies to three cases: a refused store or push leaves no trace in the data that later comes out, an empty read returns 0 without moving the pointers, and write-one-to-clear and threshold masking behave as seen at the register port.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int unsigned REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      SEL_DATA   = 3'd0,
      SEL_STATUS = 3'd1,
      SEL_ERROR  = 3'd2,
      SEL_WTHR   = 3'd3,
      SEL_RTHR   = 3'd4,
      SEL_CTRL   = 3'd5
   } reg_sel_e;

   localparam int unsigned ST_IN_EMPTY  = 0;
   localparam int unsigned ST_OUT_FULL  = 1;
   localparam int unsigned ST_OUT_ABOVE = 2;
   localparam int unsigned ST_IN_ABOVE  = 3;

   localparam int unsigned ER_UNDERRUN  = 0;
   localparam int unsigned ER_OVERRUN   = 1;

   localparam int unsigned CT_FLUSH_IN  = 0;
   localparam int unsigned CT_FLUSH_OUT = 1;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CW-1:0]     level,
   output logic              full,
   output logic              empty
);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mbox_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("mbox_fifo: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr, wptr_nx, rptr_nx;
   logic [CW-1:0]     cnt;
   logic              do_push, do_pop;

   assign full    = (cnt == DEPTH_C);
   assign empty   = (cnt == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wptr_nx = wptr + AW'(1);
      assign rptr_nx = rptr + AW'(1);
   end else begin : g_wrap
      assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   assign head  = mem[rptr];
   assign level = cnt;

   AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      level <= DEPTH_C) else $error("level above depth"); // R4
   AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop && !flush) |=> level == $past(level) + CW'(1))
      else $error("accepted push lost"); // R1
   AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> level == $past(level))
      else $error("full fifo accepted data"); // R11
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty) else $error("flush left data"); // R10
endmodule

// File: rtl/mbox_err_flags.sv
module mbox_err_flags #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   if (N < 1) begin : g_bad_n
      $error("mbox_err_flags: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flags[i] <= 1'b0;
         else if (set[i]) flags[i] <= 1'b1;
         else if (clr[i]) flags[i] <= 1'b0;
      end

      AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]) else $error("error flag not set"); // R6
      AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !clr[i]) |=> flags[i]) else $error("flag dropped"); // R6
   end
endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
   import mbox_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned THR_W  = 3,
   localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW    = AW + 1,
   localparam int unsigned CMP_W = (CW > THR_W) ? CW : THR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              hw_wr_valid,
   output logic [DATA_W-1:0] hw_wr_data,
   input  logic              hw_wr_pop,
   output logic              hw_rd_ready,
   input  logic              hw_rd_push,
   input  logic [DATA_W-1:0] hw_rd_data,
   output logic              irq_wr_thr,
   output logic              irq_rd_thr,
   output logic              irq_err
);
   if (DATA_W < 4) begin : g_bad_dw
      $error("mbox_bridge: DATA_W must hold the status word");
   end
   if (THR_W > DATA_W) begin : g_bad_thr
      $error("mbox_bridge: THR_W wider than data");
   end

   reg_sel_e sel;
   logic     acc_wr, acc_rd;
   logic     data_wr, data_rd;
   logic     out_push, out_bad, in_pop, in_bad;
   logic     flush_in, flush_out;
   logic     err_wr;

   assign sel     = reg_sel_e'(bus_addr);
   assign acc_wr  = bus_req && bus_we;
   assign acc_rd  = bus_req && !bus_we;
   assign data_wr = acc_wr && (sel == SEL_DATA);
   assign data_rd = acc_rd && (sel == SEL_DATA);
   assign err_wr  = acc_wr && (sel == SEL_ERROR);

   logic [DATA_W-1:0] out_head, in_head;
   logic [CW-1:0]     out_lvl, in_lvl;
   logic              out_full, out_empty, in_full, in_empty;

   assign out_push  = data_wr && !out_full;
   assign out_bad   = data_wr && out_full;
   assign in_pop    = data_rd && !in_empty;
   assign in_bad    = data_rd && in_empty;
   assign flush_in  = acc_wr && (sel == SEL_CTRL) && bus_wdata[CT_FLUSH_IN];
   assign flush_out = acc_wr && (sel == SEL_CTRL) && bus_wdata[CT_FLUSH_OUT];

   mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_out_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_out),
      .push      (out_push),
      .push_data (bus_wdata),
      .pop       (hw_wr_pop),
      .head      (out_head),
      .level     (out_lvl),
      .full      (out_full),
      .empty     (out_empty)
   );

   mbox_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_in_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_in),
      .push      (hw_rd_push),
      .push_data (hw_rd_data),
      .pop       (in_pop),
      .head      (in_head),
      .level     (in_lvl),
      .full      (in_full),
      .empty     (in_empty)
   );

   logic [THR_W-1:0] wthr_q, rthr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wthr_q <= '0;
         rthr_q <= '0;
      end else begin
         if (acc_wr && (sel == SEL_WTHR)) wthr_q <= bus_wdata[THR_W-1:0];
         if (acc_wr && (sel == SEL_RTHR)) rthr_q <= bus_wdata[THR_W-1:0];
      end
   end

   logic out_above, in_above;
   assign out_above = CMP_W'(out_lvl) > CMP_W'(wthr_q);
   assign in_above  = CMP_W'(in_lvl)  > CMP_W'(rthr_q);

   logic [1:0] err_set, err_clr, err_q;
   assign err_set[ER_UNDERRUN] = in_bad;
   assign err_set[ER_OVERRUN]  = out_bad;
   assign err_clr = err_wr ? bus_wdata[1:0] : 2'b00;

   mbox_err_flags #(.N(2)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (err_set),
      .clr   (err_clr),
      .flags (err_q)
   );

   logic [3:0] status;
   always_comb begin
      status               = '0;
      status[ST_IN_EMPTY]  = in_empty;
      status[ST_OUT_FULL]  = out_full;
      status[ST_OUT_ABOVE] = out_above;
      status[ST_IN_ABOVE]  = in_above;
   end

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_DATA:   bus_rdata = in_empty ? '0 : in_head;
         SEL_STATUS: bus_rdata = DATA_W'(status);
         SEL_ERROR:  bus_rdata = DATA_W'(err_q);
         SEL_WTHR:   bus_rdata = DATA_W'(wthr_q);
         SEL_RTHR:   bus_rdata = DATA_W'(rthr_q);
         default:    bus_rdata = '0;
      endcase
   end

   assign hw_wr_valid = !out_empty;
   assign hw_wr_data  = out_head;
   assign hw_rd_ready = !in_full;
   assign irq_wr_thr  = out_above;
   assign irq_rd_thr  = in_above;
   assign irq_err     = |err_q;

   AST_ERR_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_err) |-> $past(in_bad || out_bad)) else $error("spurious error irq"); // R9
   AST_WTHR_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wr_thr |-> hw_wr_valid) else $error("wr threshold irq on empty fifo"); // R8
   AST_RTHR_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rd_thr |-> !in_empty) else $error("rd threshold irq on empty fifo"); // R8
   AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_bad && !hw_rd_push) |=> in_empty) else $error("empty read moved fifo"); // R5
endmodule

// File: tb/mbox_bridge_tb.sv
module mbox_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        hw_wr_valid, hw_wr_pop = 1'b0;
   logic [31:0] hw_wr_data;
   logic        hw_rd_ready, hw_rd_push = 1'b0;
   logic [31:0] hw_rd_data = '0;
   logic        irq_wr_thr, irq_rd_thr, irq_err;

   int checks = 0;
   int errors = 0;
   logic [31:0] out_q[$];
   logic [31:0] in_q[$];

   always #2 clk = ~clk;

   mbox_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hw_wr_valid(hw_wr_valid), .hw_wr_data(hw_wr_data), .hw_wr_pop(hw_wr_pop),
      .hw_rd_ready(hw_rd_ready), .hw_rd_push(hw_rd_push), .hw_rd_data(hw_rd_data),
      .irq_wr_thr(irq_wr_thr), .irq_rd_thr(irq_rd_thr), .irq_err(irq_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_req = 1'b0;
   endtask

   // driver: software store, expected item goes into the outbound scoreboard
   task automatic sw_store(input logic [31:0] d, input bit accept);
      bus_wr(3'd0, d);
      if (accept) out_q.push_back(d);
   endtask

   // monitor side of the outbound direction
   task automatic hw_take(input string req);
      logic [31:0] exp;
      @(negedge clk);
      if (out_q.size() == 0) begin
         chk(req, {31'b0, hw_wr_valid}, 32'd0);
      end else begin
         exp = out_q.pop_front();
         chk(req, {31'b0, hw_wr_valid}, 32'd1);
         chk(req, hw_wr_data, exp);
      end
      hw_wr_pop = 1'b1;
      @(negedge clk);
      hw_wr_pop = 1'b0;
   endtask

   task automatic hw_give(input logic [31:0] d, input bit accept);
      @(negedge clk);
      chk("R11 ready", {31'b0, hw_rd_ready}, {31'b0, accept});
      hw_rd_push = 1'b1; hw_rd_data = d;
      @(negedge clk);
      hw_rd_push = 1'b0;
      if (accept) in_q.push_back(d);
   endtask

   task automatic sw_load(input string req);
      logic [31:0] got, exp;
      exp = (in_q.size() == 0) ? 32'd0 : in_q.pop_front();
      bus_rd(3'd0, got);
      chk(req, got, exp);
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] got;
      bus_rd(a, got);
      chk(req, got, exp);
   endtask

   task automatic irq_chk(input string req, input logic [2:0] exp);
      @(negedge clk);
      chk(req, {29'b0, irq_err, irq_rd_thr, irq_wr_thr}, {29'b0, exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12 reset state
      rd_chk("R12 status", 3'd1, 32'h1);
      rd_chk("R12 error", 3'd2, 32'h0);
      rd_chk("R12 wthr", 3'd3, 32'h0);
      rd_chk("R12 rthr", 3'd4, 32'h0);
      irq_chk("R12 irqs", 3'b000);
      chk("R12 wr_valid", {31'b0, hw_wr_valid}, 32'd0);
      chk("R12 rd_ready", {31'b0, hw_rd_ready}, 32'd1);

      // R1/R8 outbound path and threshold
      for (int i = 0; i < 3; i++) sw_store(32'hA000_0000 + i, 1'b1);
      rd_chk("R3 status out above", 3'd1, 32'h5);
      irq_chk("R8 wr irq high", 3'b001);
      bus_wr(3'd3, 32'hFFFF_FFFB);
      rd_chk("R7 wthr masked", 3'd3, 32'h3);
      irq_chk("R8 wr irq low at equal", 3'b000);
      sw_store(32'hA000_0003, 1'b1);
      irq_chk("R8 wr irq above", 3'b001);
      for (int i = 0; i < 4; i++) hw_take("R1 outbound order");
      chk("R1 drained", {31'b0, hw_wr_valid}, 32'd0);
      bus_wr(3'd3, 32'h0);

      // R4 overrun
      for (int i = 0; i < 8; i++) sw_store(32'hB000_0000 + i, 1'b1);
      rd_chk("R3 status full", 3'd1, 32'h7);
      sw_store(32'hDEAD_BEEF, 1'b0);
      rd_chk("R4 error overrun", 3'd2, 32'h2);
      irq_chk("R9 err irq", 3'b101);
      for (int i = 0; i < 8; i++) hw_take("R4 contents kept");
      hw_take("R11 empty pop");
      sw_store(32'hC000_0000, 1'b1);
      hw_take("R11 pop ignored when empty");

      // R6 sticky and W1C
      bus_wr(3'd2, 32'h0);
      rd_chk("R6 write 0 keeps", 3'd2, 32'h2);
      bus_wr(3'd2, 32'h2);
      rd_chk("R6 w1c clears", 3'd2, 32'h0);
      irq_chk("R9 err irq low", 3'b000);

      // R5 underrun
      sw_load("R5 empty read zero");
      rd_chk("R5 error underrun", 3'd2, 32'h1);
      bus_wr(3'd2, 32'h1);

      // R2/R8 inbound path
      hw_give(32'hD000_0000, 1'b1);
      hw_give(32'hD000_0001, 1'b1);
      rd_chk("R3 status in above", 3'd1, 32'h8);
      irq_chk("R8 rd irq", 3'b010);
      bus_wr(3'd4, 32'h2);
      rd_chk("R7 rthr", 3'd4, 32'h2);
      irq_chk("R8 rd irq equal", 3'b000);
      hw_give(32'hD000_0002, 1'b1);
      irq_chk("R8 rd irq above", 3'b010);
      for (int i = 0; i < 3; i++) sw_load("R2 inbound order");
      rd_chk("R3 status empty", 3'd1, 32'h1);

      // R11 inbound full
      for (int i = 0; i < 8; i++) hw_give(32'hE000_0000 + i, 1'b1);
      hw_give(32'hEEEE_EEEE, 1'b0);
      for (int i = 0; i < 8; i++) sw_load("R11 inbound kept");
      sw_load("R11 extra push dropped");
      bus_wr(3'd2, 32'h3);

      // R10 flush
      for (int i = 0; i < 3; i++) hw_give(32'hF100_0000 + i, 1'b1);
      for (int i = 0; i < 3; i++) sw_store(32'hF200_0000 + i, 1'b1);
      bus_wr(3'd5, 32'h1);
      in_q.delete();
      rd_chk("R10 inbound flushed", 3'd1, 32'h5);
      chk("R10 outbound kept", {31'b0, hw_wr_valid}, 32'd1);
      rd_chk("R10 ctrl reads zero", 3'd5, 32'h0);
      bus_wr(3'd5, 32'h2);
      out_q.delete();
      @(negedge clk);
      chk("R10 outbound flushed", {31'b0, hw_wr_valid}, 32'd0);
      irq_chk("R10 irqs after flush", 3'b000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule